// File: doc/BRIEF.md
# Spread-spectrum PWM switching oscillator

This block sets the switching period for a peak-current-mode power converter. It runs from a fixed system clock, counts out one switching cycle at a time, and raises a gate-on request at the start of every cycle. Within each cycle it also opens a blanking window that hides the current-sense comparator just after turn-on, enforces a minimum on-time, and clamps the on-time to three quarters of the period. The gate request drops early when the comparator reports that the sensed current has reached its feedback-derived threshold.

To spread electromagnetic emissions, the period is not constant. A triangular sweep moves the period reload value up and down by one clock at a time around the nominal value. Two frequency variants are available: a low one near 60 kHz and a high one near 115 kHz. Each variant has its own sweep depth and sweep rate, so that the sweep repeats at roughly 250 Hz. When the enable input is low, the gate request is held off and the sweep position is frozen.

With the default 24 MHz system clock, the nominal period is 400 clocks for the low variant and 209 clocks for the high variant. The blanking window lasts 7 clocks, which is about 300 ns. The minimum on-time is 10 clocks, which is about 400 ns.

Top module: `sscg_osc`

## Requirements
- R1: While reset is high, and after it is released with `en` still low, every output (`gate_req`, `blank`, `cyc_start`, `cyc_end`, `duty_max`) is 0.
- R2: When `en` is sampled high at a clock edge while the block is idle, a new cycle begins right after that edge. `cyc_start` is 1 for exactly that one clock, and `gate_req` rises in the same clock. `gate_req` never rises outside a `cyc_start` clock.
- R3: Consecutive `cyc_start` pulses are P clocks apart, where P = nominal + offset. The nominal value is 400 when the variant is low (`sel_hi`=0) and 209 when it is high (`sel_hi`=1). The offset is 0 right after reset.
- R4: The offset follows a triangle. It starts at 0 and moves upward. It changes by one step after every D completed cycles, where D is 2 for the low variant and 8 for the high variant. It reverses direction when it reaches +M or -M, where M is 27 for the low variant and 14 for the high variant. A cycle's period uses the offset value that was in force before the step taken at that cycle's own start. The low periods therefore run from 373 to 427 clocks, and the high periods reach 223 clocks.
- R5: `cyc_end` is 1 in the last clock of each cycle, which is the clock just before the next `cyc_start`.
- R6: Let the position within a cycle be counted from 0 at `cyc_start`. `duty_max` is 1 from position floor(3P/4) up to the end of the cycle. `gate_req` is 0 whenever `duty_max` is 1. With no turn-off request, `gate_req` is high for exactly floor(3P/4) clocks.
- R7: `blank` is 1 at positions 0 to 6 of each cycle. A `cs_trip` that is sampled while `blank` is 1 has no effect on `gate_req`.
- R8: A `cs_trip` that is sampled at a position p ≥ 7 is remembered for the rest of that cycle. `gate_req` goes to 0 at position max(p+1, 10) and stays at 0 until the next `cyc_start`.
- R9: `gate_req` never falls before position 10 because of a turn-off request. A request sampled at position 7, 8 or 9 still gives exactly 10 on-clocks.
- R10: When `en` is sampled low, every output is 0 from the next clock, and the current cycle is abandoned. The sweep offset, its direction and its step count are held. When `en` returns high, a fresh cycle starts with the held offset.
- R11: `sel_hi` is sampled only when a cycle is loaded. If its value differs from the variant in use, the new cycle has the new nominal period, and the sweep restarts from offset 0, moving upward, with its step count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; when low, the gate request is held off and the sweep is frozen |
| sel_hi | input | 1 | Frequency variant: 0 = low, 1 = high |
| cs_trip | input | 1 | Current-sense comparator output; 1 = threshold reached |
| gate_req | output | 1 | Gate-on request to the driver |
| blank | output | 1 | Leading-edge blanking window |
| cyc_start | output | 1 | One-clock pulse at the first clock of each cycle |
| cyc_end | output | 1 | One-clock strobe at the last clock of each cycle |
| duty_max | output | 1 | Maximum-duty limit reached in the current cycle |

## Verification
A wrong sweep state (offset, direction or step count) leaves the gate logic untouched. It shows only as a `cyc_start` spacing that is one clock off. That error appears at the first cycle loaded with the bad value, so it can take up to one full switching period to surface. A wrong position count, or a wrong pending turn-off flag, corrupts `blank`, `duty_max` or the falling edge of `gate_req` within the same cycle, often on the very next clock. For this reason, every output is compared against an independent model on every clock, and the spacing between start pulses is also measured across whole sweeps.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  typedef enum logic {
    VAR_LO = 1'b0,
    VAR_HI = 1'b1
  } sscg_var_e;

  function automatic int duty_point(input int per, input int num, input int sh);
    return (per * num) >>> sh;
  endfunction

endpackage

// File: rtl/sscg_jitter.sv
module sscg_jitter
  import sscg_pkg::*;
#(
  parameter int NOM_LO  = 400,
  parameter int NOM_HI  = 209,
  parameter int DEV_LO  = 27,
  parameter int DEV_HI  = 14,
  parameter int JDIV_LO = 2,
  parameter int JDIV_HI = 8,
  parameter int PW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          done,
  input  logic          sel_hi,
  output logic [PW-1:0] per_next
);

  localparam int DEV_MAX = (DEV_LO > DEV_HI) ? DEV_LO : DEV_HI;
  localparam int DIV_MAX = (JDIV_LO > JDIV_HI) ? JDIV_LO : JDIV_HI;
  localparam int OW      = $clog2(DEV_MAX + 1) + 1;
  localparam int JW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  sscg_var_e           var_q;
  logic signed [OW-1:0] off_q;
  logic                dir_up_q;
  logic [JW-1:0]       presc_q;

  sscg_var_e sel_var;
  logic      changed;
  int        cur_nom;
  int        cur_dev;
  int        cur_div;
  int        off_i;
  int        off_step;
  logic      presc_wrap;

  always_comb begin
    sel_var    = sel_hi ? VAR_HI : VAR_LO;
    changed    = (sel_var != var_q);
    cur_nom    = (var_q == VAR_HI) ? NOM_HI : NOM_LO;
    cur_dev    = (var_q == VAR_HI) ? DEV_HI : DEV_LO;
    cur_div    = (var_q == VAR_HI) ? JDIV_HI : JDIV_LO;
    off_i      = int'(off_q);
    off_step   = dir_up_q ? (off_i + 1) : (off_i - 1);
    presc_wrap = (int'(presc_q) >= (cur_div - 1));
    if (changed) begin
      per_next = (sel_var == VAR_HI) ? PW'(NOM_HI) : PW'(NOM_LO);
    end else begin
      per_next = PW'(cur_nom + off_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      var_q    <= VAR_LO;
      off_q    <= '0;
      dir_up_q <= 1'b1;
      presc_q  <= '0;
    end else if (load) begin
      if (changed) begin
        var_q    <= sel_var;
        off_q    <= '0;
        dir_up_q <= 1'b1;
        presc_q  <= '0;
      end else if (done) begin
        if (presc_wrap) begin
          presc_q <= '0;
          off_q   <= OW'(off_step);
          if (off_step >= cur_dev) begin
            dir_up_q <= 1'b0;
          end else if (off_step <= -cur_dev) begin
            dir_up_q <= 1'b1;
          end
        end else begin
          presc_q <= presc_q + 1'b1;
        end
      end
    end
  end

  AST_JIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (off_i <= cur_dev) && (off_i >= -cur_dev)); // R4

  AST_JIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(off_q) && $stable(dir_up_q)); // R10

endmodule

// File: rtl/sscg_timebase.sv
module sscg_timebase
  import sscg_pkg::*;
#(
  parameter int PW       = 9,
  parameter int LEB      = 7,
  parameter int DUTY_NUM = 3,
  parameter int DUTY_SH  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] per_in,
  output logic          load,
  output logic          done,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] dlim,
  output logic          cyc_start,
  output logic          cyc_end,
  output logic          blank,
  output logic          duty_max
);

  localparam logic [PW-1:0] LEB_P = PW'(LEB);

  logic          act_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] dlim_q;

  logic [PW-1:0] nxt_pos;
  logic [PW-1:0] nxt_per;
  logic [PW-1:0] nxt_dlim;
  logic [PW-1:0] dl_in;

  always_comb begin
    load  = en & (~act_q | (pos_q == (per_q - 1'b1)));
    done  = load & act_q;
    dl_in = PW'(duty_point(int'(per_in), DUTY_NUM, DUTY_SH));
    if (!en || load) begin
      nxt_pos = '0;
    end else begin
      nxt_pos = pos_q + 1'b1;
    end
    nxt_per  = load ? per_in : per_q;
    nxt_dlim = load ? dl_in  : dlim_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      pos_q     <= '0;
      per_q     <= '0;
      dlim_q    <= '0;
      cyc_start <= 1'b0;
      cyc_end   <= 1'b0;
      blank     <= 1'b0;
      duty_max  <= 1'b0;
    end else begin
      act_q     <= en;
      pos_q     <= nxt_pos;
      per_q     <= nxt_per;
      dlim_q    <= nxt_dlim;
      cyc_start <= en & (nxt_pos == '0);
      cyc_end   <= en & (nxt_pos == (nxt_per - 1'b1));
      blank     <= en & (nxt_pos < LEB_P);
      duty_max  <= en & (nxt_pos >= nxt_dlim);
    end
  end

  assign pos  = pos_q;
  assign dlim = dlim_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start); // R2

  AST_END_THEN_START: assert property (@(posedge clk) disable iff (rst)
    cyc_end && en |=> cyc_start); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !cyc_start && !cyc_end && !blank && !duty_max); // R10

endmodule

// File: rtl/sscg_gate.sv
module sscg_gate #(
  parameter int PW    = 9,
  parameter int LEB   = 7,
  parameter int MINON = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] dlim,
  input  logic          cs_trip,
  output logic          gate
);

  localparam logic [PW-1:0] LEB_P   = PW'(LEB);
  localparam logic [PW:0]   MINON_W = (PW + 1)'(MINON);

  logic          pend_q;
  logic          gate_q;
  logic [PW:0]   pos1;
  logic          trip_ok;
  logic          pend_n;
  logic          kill;

  always_comb begin
    pos1    = {1'b0, pos} + 1'b1;
    trip_ok = cs_trip & (pos >= LEB_P);
    pend_n  = pend_q | trip_ok;
    kill    = (pos1 >= {1'b0, dlim}) | (pend_n & (pos1 >= MINON_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      gate_q <= 1'b0;
    end else if (!en) begin
      pend_q <= 1'b0;
      gate_q <= 1'b0;
    end else if (load) begin
      pend_q <= 1'b0;
      gate_q <= 1'b1;
    end else begin
      pend_q <= pend_n;
      gate_q <= gate_q & ~kill;
    end
  end

  assign gate = gate_q;

  AST_GATE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate_q); // R10

  AST_MIN_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) && $past(en) |-> ({1'b0, pos} >= MINON_W)); // R9

endmodule

// File: rtl/sscg_osc.sv
module sscg_osc #(
  parameter int NOM_LO   = 400,
  parameter int NOM_HI   = 209,
  parameter int DEV_LO   = 27,
  parameter int DEV_HI   = 14,
  parameter int JDIV_LO  = 2,
  parameter int JDIV_HI  = 8,
  parameter int LEB      = 7,
  parameter int MINON    = 10,
  parameter int DUTY_NUM = 3,
  parameter int DUTY_SH  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_hi,
  input  logic cs_trip,
  output logic gate_req,
  output logic blank,
  output logic cyc_start,
  output logic cyc_end,
  output logic duty_max
);

  localparam int PER_MAX_LO = NOM_LO + DEV_LO;
  localparam int PER_MAX_HI = NOM_HI + DEV_HI;
  localparam int PER_MAX    = (PER_MAX_LO > PER_MAX_HI) ? PER_MAX_LO : PER_MAX_HI;
  localparam int PW         = $clog2(PER_MAX + 1);

  logic          load;
  logic          done;
  logic [PW-1:0] per_next;
  logic [PW-1:0] pos;
  logic [PW-1:0] dlim;

  sscg_jitter #(
    .NOM_LO (NOM_LO),
    .NOM_HI (NOM_HI),
    .DEV_LO (DEV_LO),
    .DEV_HI (DEV_HI),
    .JDIV_LO(JDIV_LO),
    .JDIV_HI(JDIV_HI),
    .PW     (PW)
  ) u_jitter (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .done    (done),
    .sel_hi  (sel_hi),
    .per_next(per_next)
  );

  sscg_timebase #(
    .PW      (PW),
    .LEB     (LEB),
    .DUTY_NUM(DUTY_NUM),
    .DUTY_SH (DUTY_SH)
  ) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .per_in   (per_next),
    .load     (load),
    .done     (done),
    .pos      (pos),
    .dlim     (dlim),
    .cyc_start(cyc_start),
    .cyc_end  (cyc_end),
    .blank    (blank),
    .duty_max (duty_max)
  );

  sscg_gate #(
    .PW   (PW),
    .LEB  (LEB),
    .MINON(MINON)
  ) u_gate (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .load   (load),
    .pos    (pos),
    .dlim   (dlim),
    .cs_trip(cs_trip),
    .gate   (gate_req)
  );

  AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (rst)
    duty_max |-> !gate_req); // R6

  AST_BLANK_KEEPS_GATE: assert property (@(posedge clk) disable iff (rst)
    blank && en |=> gate_req); // R7

  AST_GATE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_req) |-> cyc_start); // R2

endmodule

// File: tb/sscg_osc_bench.sv
module sscg_osc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic sel_hi = 1'b0;
  logic cs_trip = 1'b0;
  logic gate_req, blank, cyc_start, cyc_end, duty_max;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sscg_osc u_sscg_osc (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sel_hi   (sel_hi),
    .cs_trip  (cs_trip),
    .gate_req (gate_req),
    .blank    (blank),
    .cyc_start(cyc_start),
    .cyc_end  (cyc_end),
    .duty_max (duty_max)
  );

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  function automatic int nomf(int v); return v ? 209 : 400; endfunction
  function automatic int devf(int v); return v ? 14 : 27; endfunction
  function automatic int divf(int v); return v ? 8 : 2; endfunction

  // behavioural reference model, updated on each rising edge
  int mact, mpos, mper, mdl, mgate, mpend, mvar, moff, mdir, mpre, np;

  always @(posedge clk) begin
    if (rst) begin
      mact = 0; mpos = 0; mper = 0; mdl = 0; mgate = 0; mpend = 0;
      mvar = 0; moff = 0; mdir = 1; mpre = 0;
    end else if (!en) begin
      mact = 0; mpos = 0; mgate = 0; mpend = 0;
    end else if (!mact || mpos == mper - 1) begin
      if (int'(sel_hi) != mvar) begin
        mvar = int'(sel_hi); moff = 0; mdir = 1; mpre = 0;
        np = nomf(mvar);
      end else begin
        np = nomf(mvar) + moff;
        if (mact != 0) begin
          mpre = mpre + 1;
          if (mpre == divf(mvar)) begin
            mpre = 0;
            moff = moff + mdir;
            if (moff == devf(mvar)) mdir = -1;
            else if (moff == -devf(mvar)) mdir = 1;
          end
        end
      end
      mper = np; mdl = (np * 3) / 4; mpos = 0; mact = 1; mpend = 0; mgate = 1;
    end else begin
      if (cs_trip && mpos >= 7) mpend = 1;
      if (mpos + 1 >= mdl) mgate = 0;
      if (mpend != 0 && mpos + 1 >= 10) mgate = 0;
      mpos = mpos + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and cycle bookkeeping
  int cnt = 0, on_cnt = 0, last_on = 0;
  bit have = 0;
  int ints[$];
  int ons[$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(gate_req == (mgate != 0), "R8 gate_req", int'(gate_req), mgate);
      chk(blank == (mact != 0 && mpos < 7), "R7 blank", int'(blank), int'(mact != 0 && mpos < 7));
      chk(cyc_start == (mact != 0 && mpos == 0), "R3 cyc_start", int'(cyc_start), int'(mact != 0 && mpos == 0));
      chk(cyc_end == (mact != 0 && mpos == mper - 1), "R5 cyc_end", int'(cyc_end), int'(mact != 0 && mpos == mper - 1));
      chk(duty_max == (mact != 0 && mpos >= mdl), "R6 duty_max", int'(duty_max), int'(mact != 0 && mpos >= mdl));
    end
    if (cyc_start) begin
      if (have) begin
        ints.push_back(cnt);
        ons.push_back(on_cnt);
        last_on = on_cnt;
      end
      have = 1; cnt = 1; on_cnt = gate_req ? 1 : 0;
    end else if (have) begin
      cnt++;
      if (gate_req) on_cnt++;
    end
    if (mact == 0) have = 0;
  end

  // stimulus
  int mode = 0;  // 0 none, 1 trip at tpos, 2 pseudo-random
  int tpos = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic tick();
    @(negedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      1: cs_trip = (mact != 0 && mpos == tpos);
      2: cs_trip = lfsr[0] & lfsr[3] & lfsr[7];
      default: cs_trip = 1'b0;
    endcase
  endtask

  task automatic wait_starts(input int n);
    int k = 0;
    while (k < n) begin
      tick();
      if (cyc_start) k++;
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int mn, mx, exp_per;
    rst = 1'b1;
    repeat (5) tick();
    chk({gate_req, blank, cyc_start, cyc_end, duty_max} == 5'b0, "R1 outputs in reset", int'({gate_req, blank, cyc_start, cyc_end, duty_max}), 0);
    rst = 1'b0;
    repeat (3) tick();
    chk({gate_req, blank, cyc_start, cyc_end, duty_max} == 5'b0, "R1 idle after reset", int'({gate_req, blank, cyc_start, cyc_end, duty_max}), 0);

    // low variant start
    ints.delete(); ons.delete();
    en = 1'b1;
    tick();
    chk(cyc_start && gate_req, "R2 first start", int'({cyc_start, gate_req}), 3);
    tick();
    chk(!cyc_start && gate_req, "R2 start pulse width", int'(cyc_start), 0);
    wait_starts(4);
    chk(ints[0] == 400, "R3 low nominal period", ints[0], 400);
    chk(ints[3] == 401, "R4 first sweep step", ints[3], 401);
    chk(ons[0] == 300, "R6 clamp on-time", ons[0], 300);

    // turn-off at position 50
    mode = 1; tpos = 50;
    wait_starts(1);
    chk(last_on == 51, "R8 turn-off at 50", last_on, 51);
    // request inside blanking is ignored
    tpos = 3;
    wait_starts(1);
    chk(last_on == (ints[ints.size()-1] * 3) / 4, "R7 blanked trip ignored", last_on, (ints[ints.size()-1] * 3) / 4);
    // minimum on-time hold-off
    tpos = 7;
    wait_starts(1);
    chk(last_on == 10, "R9 trip at 7", last_on, 10);
    tpos = 9;
    wait_starts(1);
    chk(last_on == 10, "R9 trip at 9", last_on, 10);
    tpos = 10;
    wait_starts(1);
    chk(last_on == 11, "R8 trip at 10", last_on, 11);

    mode = 2;
    wait_starts(20);
    mode = 0;
    wait_starts(170 - ints.size());
    mn = 100000; mx = 0;
    foreach (ints[i]) begin
      if (ints[i] < mn) mn = ints[i];
      if (ints[i] > mx) mx = ints[i];
    end
    chk(mx == 427, "R4 low sweep maximum", mx, 427);
    chk(mn == 373, "R4 low sweep minimum", mn, 373);

    // disable mid-cycle
    while (!(mact != 0 && mpos == 100)) tick();
    en = 1'b0;
    tick();
    chk({gate_req, blank, cyc_start, cyc_end, duty_max} == 5'b0, "R10 outputs off", int'({gate_req, blank, cyc_start, cyc_end, duty_max}), 0);
    repeat (4) tick();
    chk(gate_req == 1'b0, "R10 gate stays off", int'(gate_req), 0);
    en = 1'b1;
    tick();
    chk(cyc_start && gate_req, "R10 restart", int'({cyc_start, gate_req}), 3);
    exp_per = mper;
    ints.delete();
    wait_starts(1);
    chk(ints[0] == exp_per, "R10 held sweep period", ints[0], exp_per);

    // variant switch to high
    sel_hi = 1'b1;
    wait_starts(1);
    ints.delete();
    wait_starts(10);
    for (int i = 0; i < 9; i++) chk(ints[i] == 209, "R11 high period after switch", ints[i], 209);
    chk(ints[9] == 210, "R4 high first step", ints[9], 210);
    wait_starts(110);
    mx = 0;
    foreach (ints[i]) if (ints[i] > mx) mx = ints[i];
    chk(mx == 223, "R4 high sweep maximum", mx, 223);

    // back to low: recentred
    sel_hi = 1'b0;
    wait_starts(1);
    ints.delete();
    wait_starts(1);
    chk(ints[0] == 400, "R11 low recentred", ints[0], 400);

    finish_up();
  end

endmodule